// File: doc/BRIEF.md
# Strobe-Captured Single-Bit Static RAM

This block is a memory of 4096 one-bit words in which every access is framed by an active-low enable strobe. When the strobe falls, the block captures the address, the write-enable and the data input into internal registers. Those captured values govern the whole access. Changes on those inputs later in the access have no effect. When the strobe returns high, the access ends, the output goes back to high impedance, and the captured values are released.

The captured write-enable decides the kind of access. If it was high, the access is a read, and the stored bit at the captured address is driven for as long as the strobe stays low. If it was low, the access is an early write. The data bit captured at the falling edge is committed to the array, and the output stays in high impedance for the whole access. The tri-stateable pin is represented by a data bit and a separate output-enable flag. Every signal is sampled on a system clock, and a falling edge of the strobe is seen as high on one clock edge followed by low on the next.

Top module: `sram_edge_4k`

## Requirements
- R1: While rst_ni is low, doe_o and dout_o are both 0.
- R2: A read returns the bit at the address present on the clock edge where en_ni is first seen low. Later address changes in the same access are ignored.
- R3: If we_ni is 1 at that edge, doe_o is 1 from the next clock on, and dout_o carries the stored bit for as long as en_ni stays low.
- R4: If we_ni is 0 at that edge, doe_o stays 0 for the whole access, whatever we_ni does later.
- R5: An early write stores the din_i value present at the capture edge. Later changes on din_i are ignored.
- R6: One clock after en_ni is seen high, doe_o is 0. While en_ni is high, we_ni, addr_i and din_i have no effect on the array or on the output.
- R7: En_ni high for a single clock edge followed by low starts a fresh access with a new capture.
- R8: A bit written in one access is returned by a read of the same address in the next access.
- R9: Holding en_ni low for many clocks starts no new access: dout_o and doe_o stay stable.
- R10: dout_o is 0 whenever doe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_ni | input | 1 | Active-low access strobe |
| we_ni | input | 1 | Active-low write-enable, captured at strobe fall |
| addr_i | input | 12 | Word address, captured at strobe fall |
| din_i | input | 1 | Write data, captured at strobe fall |
| dout_o | output | 1 | Read data, valid while doe_o is 1 |
| doe_o | output | 1 | Output-enable, 0 means high impedance |

## Verification
The bench changes the address, write-enable and data inputs in the middle of an access. A design that samples them as levels instead of capturing them would read the wrong word, store the inverted bit, or switch on its output during a write. It drives the inputs while the strobe is high and then reads the affected word back, which exposes a design that writes while idle. It also holds the strobe low for a long stretch and leaves it high for only one clock between accesses. A design that re-triggers on a low level would change its output part way through the stretch. One that misses the falling edge would fail to start the second access.

// File: rtl/sram_edge_pkg.sv
`timescale 1ns/1ps
package sram_edge_pkg;
  localparam int DEF_ADDR_W = 12;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_edge_strobe.sv
`timescale 1ns/1ps
// Detects strobe fall (start) from the previously sampled level.
module sram_edge_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic start_o,
  output logic idle_o
);
  logic en_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_prev_q <= 1'b1;
    else         en_prev_q <= en_ni;
  end

  assign start_o = en_prev_q & ~en_ni;
  assign idle_o  = en_ni;
endmodule

// File: rtl/sram_edge_ctrl.sv
`timescale 1ns/1ps
// Holds the access kind decided by the captured write-enable.
module sram_edge_ctrl
  import sram_edge_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic idle_i,
  input  logic we_ni,
  output logic rd_cap_o,
  output logic wr_cap_o,
  output logic drive_o
);
  cyc_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (idle_i)       state_d = CYC_IDLE;
    else if (start_i) state_d = we_ni ? CYC_READ : CYC_WRITE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CYC_IDLE;
    else         state_q <= state_d;
  end

  assign rd_cap_o = start_i & we_ni;
  assign wr_cap_o = start_i & ~we_ni;
  assign drive_o  = (state_q == CYC_READ);
endmodule

// File: rtl/sram_edge_array.sv
`timescale 1ns/1ps
// Bit array: write commits at capture, read bit registered at capture.
module sram_edge_array #(
  parameter int ADDR_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              rbit_o
);
  logic [DEPTH-1:0] mem_q;
  logic             rbit_q;

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[addr_i] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rbit_q <= 1'b0;
    else if (rd_i) rbit_q <= mem_q[addr_i];
  end

  assign rbit_o = rbit_q;
endmodule

// File: rtl/sram_edge_4k.sv
`timescale 1ns/1ps
module sram_edge_4k
  import sram_edge_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              doe_o
);
  logic start, idle, rd_cap, wr_cap, drive, rbit;

  sram_edge_strobe u_strobe (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_ni (en_ni),
    .start_o (start), .idle_o (idle)
  );

  sram_edge_ctrl u_ctrl (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start), .idle_i (idle),
    .we_ni (we_ni), .rd_cap_o (rd_cap), .wr_cap_o (wr_cap), .drive_o (drive)
  );

  sram_edge_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (wr_cap), .rd_i (rd_cap),
    .addr_i (addr_i), .din_i (din_i), .rbit_o (rbit)
  );

  assign doe_o  = drive;
  assign dout_o = drive & rbit;
endmodule

// File: rtl/sram_edge_4k_chk.sv
`timescale 1ns/1ps
module sram_edge_4k_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_ni,
  input logic we_ni,
  input logic dout_o,
  input logic doe_o
);
  logic seen_hi_q;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_hi_q <= 1'b1;
    else         seen_hi_q <= en_ni;
  end
  assign fall = seen_hi_q & ~en_ni;

  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!doe_o && !dout_o);
  end

  assert_read_drives_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && we_ni) |=> doe_o);

  assert_write_hiz_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall && !we_ni) |=> !doe_o);

  assert_write_hiz_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && !fall && !doe_o) |=> !doe_o);

  assert_idle_hiz_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_ni |=> !doe_o);

  assert_hold_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_ni && !fall && doe_o) |=> (doe_o && $stable(dout_o)));

  assert_quiet_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !doe_o |-> !dout_o);
endmodule

bind sram_edge_4k sram_edge_4k_chk u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .en_ni (en_ni), .we_ni (we_ni),
  .dout_o (dout_o), .doe_o (doe_o)
);

// File: tb/sim_sram_edge_4k.sv
`timescale 1ns/1ps
module sim_sram_edge_4k;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_n = 1'b1, we_n = 1'b1, din = 1'b0;
  logic [11:0] addr = '0;
  logic        dout, doe;
  logic        ref_mem [4096];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sram_edge_4k u0 (
    .clk_i (clk), .rst_ni (rst_n), .en_ni (en_n), .we_ni (we_n),
    .addr_i (addr), .din_i (din), .dout_o (dout), .doe_o (doe)
  );

  // {we_n, addr, din}
  localparam logic [13:0] VEC [16] = '{
    {1'b0, 12'h000, 1'b1}, {1'b0, 12'hFFF, 1'b1}, {1'b0, 12'h555, 1'b0},
    {1'b0, 12'hAAA, 1'b1}, {1'b0, 12'h001, 1'b0}, {1'b0, 12'h800, 1'b1},
    {1'b1, 12'h000, 1'b0}, {1'b1, 12'hFFF, 1'b0}, {1'b1, 12'h555, 1'b1},
    {1'b1, 12'hAAA, 1'b0}, {1'b1, 12'h001, 1'b1}, {1'b1, 12'h800, 1'b0},
    {1'b0, 12'h000, 1'b0}, {1'b1, 12'h000, 1'b1}, {1'b0, 12'h555, 1'b1},
    {1'b1, 12'h555, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One access; scramble flips inputs after capture.
  task automatic access(input logic w, input logic [11:0] a, input logic d,
                        input logic scramble);
    @(negedge clk);
    en_n = 1'b0; we_n = w; addr = a; din = d;
    @(negedge clk);
    if (scramble) begin we_n = ~w; addr = ~a; din = ~d; end
    @(negedge clk);
    if (w) begin
      chk("R3 doe on read", doe, 1'b1);
      chk(scramble ? "R2 read data addr held" : "R8 read data", dout, ref_mem[a]);
    end else begin
      chk("R4 doe low on write", doe, 1'b0);
      chk("R10 dout low on write", dout, 1'b0);
      ref_mem[a] = d;
    end
    en_n = 1'b1; we_n = 1'b0; din = ~din;
    @(negedge clk);
    chk("R6 doe low after release", doe, 1'b0);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) ref_mem[i] = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 doe in reset", doe, 1'b0);
    chk("R1 dout in reset", dout, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++)
      access(VEC[i][13], VEC[i][12:1], VEC[i][0], 1'b0);

    // R5 / R4: data and write-enable flipped mid-write, then read back
    access(1'b0, 12'h123, 1'b1, 1'b1);
    access(1'b1, 12'h123, 1'b0, 1'b0);
    access(1'b0, 12'h123, 1'b0, 1'b1);
    access(1'b1, 12'h123, 1'b1, 1'b0);
    chk("R5 captured din stored", ref_mem[12'h123], 1'b0);

    // R2: address flipped mid-read (0x0F0 vs 0xF0F hold different bits)
    access(1'b0, 12'h0F0, 1'b1, 1'b0);
    access(1'b0, 12'hF0F, 1'b0, 1'b0);
    access(1'b1, 12'h0F0, 1'b0, 1'b1);

    // R6: inputs toggled while idle must not write
    @(negedge clk);
    en_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      we_n = 1'b0; addr = 12'h0F0; din = i[0];
      @(negedge clk);
      chk("R6 doe low while idle", doe, 1'b0);
    end
    access(1'b1, 12'h0F0, 1'b0, 1'b0);

    // R9: strobe held low, address and we wander
    @(negedge clk);
    en_n = 1'b0; we_n = 1'b1; addr = 12'hFFF;
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      addr = 12'h555; we_n = i[0];
      @(negedge clk);
      chk("R9 doe held", doe, 1'b1);
      chk("R9 dout held", dout, ref_mem[12'hFFF]);
    end

    // R7: strobe high one edge, then fresh read of another word
    en_n = 1'b1;
    @(negedge clk);
    en_n = 1'b0; we_n = 1'b1; addr = 12'h800;
    @(negedge clk);
    @(negedge clk);
    chk("R7 new access doe", doe, 1'b1);
    chk("R7 new access data", dout, ref_mem[12'h800]);
    en_n = 1'b1;
    @(negedge clk);
    en_n = 1'b0; we_n = 1'b0; addr = 12'h800; din = ~ref_mem[12'h800];
    ref_mem[12'h800] = din;
    @(negedge clk);
    @(negedge clk);
    chk("R7 back-to-back write hiz", doe, 1'b0);
    en_n = 1'b1;
    @(negedge clk);
    access(1'b1, 12'h800, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule